// File: doc/BRIEF.md
# ESF Superframe Overhead Generator

This block builds the outgoing line bit stream of a DS1 transmitter that runs in the 24-frame extended superframe format. Each frame is 193 bits long. Bit position 0 is the overhead (S) bit, and the 192 bits after it are 24 eight-bit channels. The block counts bit positions and frames on its own and writes the overhead bit into position 0. Depending on the frame, that bit is part of the alignment pattern, one bit of the CRC-6 check value or one bit of the serial data link. All other positions carry the payload bit unchanged.

The block computes a CRC-6 over every superframe and sends it in the superframe that follows. The generator is x^6 + x + 1, the initial value is zero, and each overhead position counts as a one. The block also flags the channel bits in which robbed-bit signalling travels and tells which of the four signalling bits (A to D) belongs there, so an upstream stage can put the state in place. A bit strobe advances the block by one line bit. A resync strobe forces the current bit to be the overhead bit of frame 1.

Top module: `esf_ovh_gen`

## Requirements
- R1: While reset is held, and after it until the first strobe, `line_bit`, `ovh_slot`, `sig_slot` and `sig_sel` are 0. The CRC value that will be sent is all zeros until the first superframe is complete.
- R2: A frame is 193 strobed bits. Position 0 is the overhead slot and is reported by `ovh_slot`=1. At positions 1 to 192, `line_bit` equals the `pay_bit` that was presented with the strobe. Every output appears in the clock cycle after its strobe.
- R3: In frames 4, 8, 12, 16, 20 and 24, the overhead bit is 0, 0, 1, 0, 1, 1 in that order.
- R4: Frames 2, 6, 10, 14, 18 and 22 carry the check bits C1 to C6 of the previous complete superframe, with C1 being the x^5 coefficient. That value is the remainder of (message · x^6) divided by x^6 + x + 1. The message is all 4632 bits of the superframe with each overhead position taken as 1.
- R5: In odd-numbered frames the overhead bit is the `fdl_bit` presented with that strobe. `fdl_take` is 1 during exactly those strobes.
- R6: In frames 6, 12, 18 and 24, `sig_slot` is 1 for the last (eighth) bit of every channel, that is, for positions that are multiples of 8. `sig_sel` then reads 0, 1, 2 or 3 for A, B, C or D. Everywhere else both outputs are 0.
- R7: Cycles without `bit_stb` leave all registered outputs unchanged.
- R8: A strobe together with `sf_sync` makes that bit the overhead bit of frame 1. The partial CRC is discarded and the check value waiting to be sent is kept.
- R9: After frame 24 the count returns to frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One line bit is consumed in this cycle |
| sf_sync | input | 1 | With `bit_stb`: this bit is frame 1, position 0 |
| pay_bit | input | 1 | Payload bit for the current position |
| fdl_bit | input | 1 | Serial data-link bit |
| fdl_take | output | 1 | The current strobe takes `fdl_bit` |
| line_bit | output | 1 | Outgoing line bit |
| ovh_slot | output | 1 | `line_bit` is an overhead bit |
| sig_slot | output | 1 | `line_bit` sits in a signalling position |
| sig_sel | output | 2 | Signalling bit index, 0=A to 3=D |

## Verification
The main function is driven with four payload patterns: all zeros, all ones, a pseudo-random sequence and an alternating sequence. The data link gets its own pseudo-random sequence. All-zero and all-one superframes give two different check values, so an inverted overhead input or a wrong feedback tap shows up in the next superframe's C-bits. The random superframe exposes an error in bit ordering. A resync in the middle of a superframe shows whether the partial CRC is dropped and the held one kept. Idle gaps between strobes test output hold and counter stall.

// File: rtl/esf_ovh_pkg.sv
package esf_ovh_pkg;

  localparam int CRC_W = 6;

  typedef enum logic [1:0] {
    SB_LINK  = 2'd0,
    SB_CHECK = 2'd1,
    SB_ALIGN = 2'd2
  } sbit_kind_e;

  // One serial step of an LFSR that divides message*x^CRC_W by the generator.
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0] r,
    input logic             d,
    input logic [CRC_W-1:0] poly_low
  );
    logic fb;
    fb = d ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? poly_low : '0);
  endfunction

  // Frame index is zero based: index 0 is frame 1.
  function automatic sbit_kind_e sbit_kind(input int unsigned fidx);
    if (fidx % 2 == 0)      return SB_LINK;
    else if (fidx % 4 == 1) return SB_CHECK;
    else                    return SB_ALIGN;
  endfunction

endpackage

// File: rtl/esf_frame_timer.sv
module esf_frame_timer #(
  parameter int CHANS   = 24,
  parameter int CH_BITS = 8,
  parameter int FRAMES  = 24,
  localparam int FRAME_BITS = 1 + CHANS * CH_BITS,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             sf_sync,
  output logic [POS_W-1:0] cur_pos,
  output logic [FRM_W-1:0] cur_frm,
  output logic             sf_end,
  output logic             restart
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(FRAMES - 1);

  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frm_q;
  logic             last_bit, last_frm;

  assign restart  = bit_stb && sf_sync;
  assign cur_pos  = restart ? '0 : pos_q;
  assign cur_frm  = restart ? '0 : frm_q;
  assign last_bit = (cur_pos == LAST_POS);
  assign last_frm = (cur_frm == LAST_FRM);
  assign sf_end   = bit_stb && last_bit && last_frm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      frm_q <= '0;
    end else if (bit_stb) begin
      if (last_bit) begin
        pos_q <= '0;
        frm_q <= last_frm ? '0 : cur_frm + 1'b1;
      end else begin
        pos_q <= cur_pos + 1'b1;
        frm_q <= cur_frm;
      end
    end
  end

  a_r2_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !sf_sync && pos_q == LAST_POS) |=> (pos_q == '0));
  a_r9_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !sf_sync && pos_q == LAST_POS && frm_q == LAST_FRM) |=> (frm_q == '0));
  a_r9_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q <= LAST_FRM);
  a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && sf_sync) |=> (pos_q == POS_W'(1) && frm_q == '0));
  a_r7_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(pos_q) && $stable(frm_q)));

endmodule

// File: rtl/esf_crc6_acc.sv
module esf_crc6_acc
  import esf_ovh_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_LOW = 6'b000011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             restart,
  input  logic             sf_end,
  input  logic             din,
  output logic [CRC_W-1:0] crc_hold
);
  logic [CRC_W-1:0] acc_q;
  logic [CRC_W-1:0] acc_base, acc_nxt;

  assign acc_base = restart ? '0 : acc_q;
  assign acc_nxt  = crc_step(acc_base, din, POLY_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      crc_hold <= '0;
    end else if (bit_stb) begin
      if (sf_end) begin
        crc_hold <= acc_nxt;
        acc_q    <= '0;
      end else begin
        acc_q <= acc_nxt;
      end
    end
  end

  a_r4_hold_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_end |=> $stable(crc_hold));
  a_r4_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sf_end |=> (acc_q == '0));
  a_r8_keep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> $stable(crc_hold));

endmodule

// File: rtl/esf_sbit_sel.sv
module esf_sbit_sel
  import esf_ovh_pkg::*;
#(
  parameter int CHANS     = 24,
  parameter int CH_BITS   = 8,
  parameter int FRAMES    = 24,
  parameter int SIG_EVERY = 6,
  parameter logic [CRC_W-1:0] ALIGN_PAT = 6'b001011,
  localparam int FRAME_BITS = 1 + CHANS * CH_BITS,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [FRM_W-1:0] cur_frm,
  input  logic [CRC_W-1:0] crc_hold,
  input  logic             pay_bit,
  input  logic             fdl_bit,
  output logic             crc_din,
  output logic             fdl_take,
  output logic             line_bit,
  output logic             ovh_slot,
  output logic             sig_slot,
  output logic [1:0]       sig_sel
);
  sbit_kind_e   kind;
  logic         at_ovh;
  logic [2:0]   grp;
  logic         sbit_val, sig_hit;
  logic [1:0]   sig_idx;
  int unsigned  fnum;

  assign at_ovh   = (cur_pos == '0);
  assign kind     = sbit_kind(int'(cur_frm));
  assign grp      = 3'(cur_frm >> 2);
  assign fnum     = int'(cur_frm) + 1;
  assign fdl_take = bit_stb && at_ovh && (kind == SB_LINK);
  assign crc_din  = at_ovh ? 1'b1 : pay_bit;

  always_comb begin
    unique case (kind)
      SB_LINK:  sbit_val = fdl_bit;
      SB_CHECK: sbit_val = crc_hold[CRC_W-1-int'(grp)];
      default:  sbit_val = ALIGN_PAT[CRC_W-1-int'(grp)];
    endcase
  end

  assign sig_hit = !at_ovh && (fnum % SIG_EVERY == 0) &&
                   (int'(cur_pos) % CH_BITS == 0);
  assign sig_idx = 2'(fnum / SIG_EVERY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_bit <= 1'b0;
      ovh_slot <= 1'b0;
      sig_slot <= 1'b0;
      sig_sel  <= 2'd0;
    end else if (bit_stb) begin
      line_bit <= at_ovh ? sbit_val : pay_bit;
      ovh_slot <= at_ovh;
      sig_slot <= sig_hit;
      sig_sel  <= sig_hit ? sig_idx : 2'd0;
    end
  end

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable({line_bit, ovh_slot, sig_slot, sig_sel}));
  a_r5_take_only_odd: assert property (@(posedge clk) disable iff (!rst_n)
    fdl_take |-> (bit_stb && cur_pos == '0 && !cur_frm[0]));
  a_r6_sig_not_ovh: assert property (@(posedge clk) disable iff (!rst_n)
    sig_slot |-> !ovh_slot);
  a_r6_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_slot |-> (sig_sel == 2'd0));
  a_r3_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && at_ovh && cur_frm == FRM_W'(3)) |=> (line_bit == 1'b0 && ovh_slot));
  a_r3_align_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && at_ovh && cur_frm == FRM_W'(23)) |=> (line_bit == 1'b1 && ovh_slot));
  a_r2_payload_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !at_ovh) |=> (line_bit == $past(pay_bit) && !ovh_slot));

endmodule

// File: rtl/esf_ovh_gen.sv
module esf_ovh_gen
  import esf_ovh_pkg::*;
#(
  parameter int CHANS     = 24,
  parameter int CH_BITS   = 8,
  parameter int FRAMES    = 24,
  parameter int SIG_EVERY = 6,
  parameter logic [CRC_W-1:0] POLY_LOW  = 6'b000011,
  parameter logic [CRC_W-1:0] ALIGN_PAT = 6'b001011,
  localparam int FRAME_BITS = 1 + CHANS * CH_BITS,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       sf_sync,
  input  logic       pay_bit,
  input  logic       fdl_bit,
  output logic       fdl_take,
  output logic       line_bit,
  output logic       ovh_slot,
  output logic       sig_slot,
  output logic [1:0] sig_sel
);
  logic [POS_W-1:0] cur_pos;
  logic [FRM_W-1:0] cur_frm;
  logic             sf_end, restart, crc_din;
  logic [CRC_W-1:0] crc_hold;

  esf_frame_timer #(.CHANS(CHANS), .CH_BITS(CH_BITS), .FRAMES(FRAMES)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sf_sync(sf_sync),
    .cur_pos(cur_pos), .cur_frm(cur_frm), .sf_end(sf_end), .restart(restart)
  );

  esf_crc6_acc #(.POLY_LOW(POLY_LOW)) u_crc (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .restart(restart),
    .sf_end(sf_end), .din(crc_din), .crc_hold(crc_hold)
  );

  esf_sbit_sel #(.CHANS(CHANS), .CH_BITS(CH_BITS), .FRAMES(FRAMES),
                 .SIG_EVERY(SIG_EVERY), .ALIGN_PAT(ALIGN_PAT)) u_sel (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .cur_pos(cur_pos),
    .cur_frm(cur_frm), .crc_hold(crc_hold), .pay_bit(pay_bit),
    .fdl_bit(fdl_bit), .crc_din(crc_din), .fdl_take(fdl_take),
    .line_bit(line_bit), .ovh_slot(ovh_slot), .sig_slot(sig_slot),
    .sig_sel(sig_sel)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!line_bit && !ovh_slot && !sig_slot && sig_sel == 2'd0));

endmodule

// File: tb/test_esf_ovh_gen.sv
module test_esf_ovh_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, sf_sync = 1'b0, pay_bit = 1'b0, fdl_bit = 1'b0;
  logic fdl_take, line_bit, ovh_slot, sig_slot;
  logic [1:0] sig_sel;

  always #2 clk = ~clk;

  esf_ovh_gen i_esf_ovh_gen (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sf_sync(sf_sync),
    .pay_bit(pay_bit), .fdl_bit(fdl_bit), .fdl_take(fdl_take),
    .line_bit(line_bit), .ovh_slot(ovh_slot), .sig_slot(sig_slot),
    .sig_sel(sig_sel)
  );

  typedef struct {
    logic       line;
    logic       ovh;
    logic       sig;
    logic [1:0] sel;
    int         tag;
  } exp_t;

  exp_t exp_q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  int   m_pos = 0, m_frm = 0;
  logic [6:0] m_div = '0;
  logic [5:0] m_hold = '0;
  bit   after_sync = 0;
  logic [15:0] pay_lfsr = 16'hACE1;
  logic [15:0] fdl_lfsr = 16'h1D0F;

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input int tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag_name(tag), what, act, exp);
    end
  endtask

  // long-division form of the check value: shift in, subtract generator on overflow
  function automatic logic [6:0] div_step(input logic [6:0] d, input logic b);
    logic [6:0] n;
    n = {d[5:0], b};
    if (n[6]) n = n ^ 7'b1000011;
    return n;
  endfunction

  task automatic send_bit(input logic pay, input logic sync);
    exp_t e;
    logic sbit, feed, dl;
    int   n;
    @(negedge clk);
    if (sync) begin m_pos = 0; m_frm = 0; m_div = '0; after_sync = 1; end
    fdl_lfsr = {fdl_lfsr[14:0], fdl_lfsr[15] ^ fdl_lfsr[13] ^ fdl_lfsr[12] ^ fdl_lfsr[10]};
    dl = fdl_lfsr[0];
    n = m_frm + 1;
    e.tag = 2;
    if (m_pos == 0) begin
      if (n % 4 == 0) begin
        sbit = (6'b001011 >> (6 - n / 4)) & 1'b1;  // R3 pattern, frame 4 first
        e.tag = 3;
      end else if (n % 2 == 0) begin
        sbit = m_hold[5 - (n - 2) / 4];            // R4 C1..C6
        e.tag = after_sync ? 8 : 4;
      end else begin
        sbit = dl;                                 // R5 data link
        e.tag = 5;
      end
      if (n == 1 && m_frm == 0 && !sync && !after_sync) e.tag = (e.tag == 5) ? 9 : e.tag;
      if (sync) e.tag = 8;
    end else sbit = 1'b0;
    e.line = (m_pos == 0) ? sbit : pay;
    e.ovh  = (m_pos == 0);
    e.sig  = (m_pos != 0) && (n % 6 == 0) && (m_pos % 8 == 0);
    e.sel  = e.sig ? 2'(n / 6 - 1) : 2'd0;
    if (e.sig) e.tag = 6;
    feed = (m_pos == 0) ? 1'b1 : pay;
    m_div = div_step(m_div, feed);
    if (m_pos == 192 && m_frm == 23) begin
      logic [6:0] t;
      t = m_div;
      for (int k = 0; k < 6; k++) t = div_step(t, 1'b0);
      m_hold = t[5:0];
      m_div = '0;
      after_sync = 0;
    end
    if (m_pos == 192) begin m_pos = 0; m_frm = (m_frm == 23) ? 0 : m_frm + 1; end
    else m_pos++;
    bit_stb = 1'b1; sf_sync = sync; pay_bit = pay; fdl_bit = dl;
    #1;
    check(5, "fdl_take", int'(fdl_take), int'(e.ovh && (n % 2 == 1 || sync)));
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    bit_stb = 1'b0; sf_sync = 1'b0;
    pay_bit = ~pay_bit; fdl_bit = ~fdl_bit;
    @(posedge clk);
  endtask

  // monitor: compare registered outputs one cycle after each strobe
  initial begin
    logic took;
    logic [4:0] last;
    last = '0;
    forever begin
      @(posedge clk);
      took = bit_stb && rst_n;
      #1;
      if (took && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "line_bit", int'(line_bit), int'(e.line));
        check(e.tag, "ovh_slot", int'(ovh_slot), int'(e.ovh));
        check(e.tag, "sig_slot", int'(sig_slot), int'(e.sig));
        check(e.tag, "sig_sel",  int'(sig_sel),  int'(e.sel));
      end else if (rst_n && !took && !done) begin
        check(7, "hold", int'({line_bit, ovh_slot, sig_slot, sig_sel}), int'(last));
      end
      last = {line_bit, ovh_slot, sig_slot, sig_sel};
    end
  end

  task automatic run_sf(input int mode, input int sync_at);
    logic p;
    for (int i = 0; i < 4632; i++) begin
      pay_lfsr = {pay_lfsr[14:0], pay_lfsr[15] ^ pay_lfsr[14] ^ pay_lfsr[12] ^ pay_lfsr[3]};
      case (mode)
        0: p = 1'b0;
        1: p = 1'b1;
        2: p = pay_lfsr[0];
        default: p = i[0];
      endcase
      send_bit(p, (i == sync_at));
      if (i % 97 == 50) idle();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(1, "reset line_bit", int'(line_bit), 0);
    check(1, "reset ovh_slot", int'(ovh_slot), 0);
    check(1, "reset sig_slot", int'(sig_slot), 0);
    check(1, "reset sig_sel",  int'(sig_sel),  0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    run_sf(0, -1);   // check bits all zero: nothing complete yet (R1, R4)
    run_sf(1, -1);
    run_sf(2, -1);
    run_sf(3, 1800); // R8: resync mid superframe
    run_sf(2, -1);
    run_sf(0, -1);
    idle(); idle();
    done = 1;
    if (exp_q.size() != 0) check(2, "queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule